// File: doc/BRIEF.md
# Status Register Write Filter

This block holds a 32-bit processor status register that software updates through a single write strobe. A configurable bitmask decides which bits a write can reach, and the bits outside it keep their value. When the revision-6 rule set is selected, the write is filtered further. The three address-segment enables are chained so that a lower-privilege enable cannot remain on without the one above it. The reserved mode encoding is refused. The soft-reset and NMI flags can be cleared by software but never set by it.

When multithreading support is on, each write also rebuilds a per-thread status copy. The usable field, the MX bit and the mode field are copied from the new status value into their thread positions, and the address-space ID from the input is inserted. All other thread bits keep their value. When 64-bit support is on and a write turns off a segment enable that was set before, a one-cycle translation-flush request is raised in the cycle after the write.

Top module: `status_write_unit`

## Requirements
- R1: A synchronous active-high reset loads RESET_STATUS (default 0x0018_00E0) into the status register and RESET_THREAD (default 0x0055_0000) into the thread copy, and clears the flush request.
- R2: On a write, each status bit whose WRITE_MASK bit is 1 takes the write data bit, and each other bit keeps its value. The default mask is 0xF118_00F8.
- R3: With revision-6 mode and 64-bit support both on, the write data for the kernel (bit 7), supervisor (bit 6) and user (bit 5) segment enables is chained before merging: supervisor = data[6] AND kernel, and user = data[5] AND supervisor.
- R4: With revision-6 mode off, the segment-enable bits are written as given, without chaining.
- R5: In revision-6 mode, if both mode bits (4:3) are writable and the write data holds 2'b11 there, the mode field keeps its old value. With revision-6 mode off, 2'b11 is written.
- R6: In revision-6 mode, a write can clear SR (bit 20) and NMI (bit 19) but cannot set them. With revision-6 mode off, both bits can be set.
- R7: When 64-bit support is on and a write clears any of bits 7:5 that was 1 before, flush_req is 1 for exactly the one cycle after the write. Otherwise it stays 0.
- R8: With mt_en on, a write loads the thread copy as follows: bits 31:28 take status 31:28 (usable), bit 27 takes status bit 24 (MX), bits 12:11 take status 4:3 (mode), and bits 7:0 take asid_in. All other thread bits are unchanged. All of these use the status value after the write.
- R9: With mt_en off, a write leaves the thread copy unchanged.
- R10: With wr_en low, neither the status register nor the thread copy changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | 32 | Value written by software |
| rev6_mode | input | 1 | Selects the revision-6 write rules |
| seg64_en | input | 1 | 64-bit support present (segment chaining and flush) |
| mt_en | input | 1 | Multithreading support; enables the thread copy update |
| asid_in | input | 8 | Address-space ID inserted into the thread copy |
| status_q | output | 32 | Current status register |
| thread_q | output | 32 | Current per-thread status copy |
| flush_req | output | 1 | One-cycle translation-flush request |

## Verification
The hardest case is the flush after the chaining rule itself clears a segment enable. The software writes a 1 to supervisor and user but a 0 to kernel, so only the filter can produce the loss of all three enables. To reach it, the stimulus first sets all enables with a plain write, then issues that chained write in revision-6 mode with 64-bit support. It checks both the pulse and its fall one cycle later. The write-zero-only flags need an earlier write with revision-6 mode off to set them, because only then does the refused set in revision-6 mode show at the port.

// File: rtl/stw_pkg.sv
package stw_pkg;

    localparam int DATA_W = 32;

    // status bit positions
    localparam int ST_CU_LO  = 28;
    localparam int ST_MX     = 24;
    localparam int ST_SR     = 20;
    localparam int ST_NMI    = 19;
    localparam int ST_KSEG   = 7;
    localparam int ST_SSEG   = 6;
    localparam int ST_USEG   = 5;
    localparam int ST_MODE_LO = 3;

    // thread copy positions
    localparam int TH_CU_LO   = 28;
    localparam int TH_MX      = 27;
    localparam int TH_MODE_LO = 11;

    typedef struct packed {
        logic [3:0] usable;
        logic       mx;
        logic [1:0] mode;
    } mirror_fields_t;

    function automatic mirror_fields_t pick_fields(input logic [DATA_W-1:0] st);
        mirror_fields_t f;
        f.usable = st[ST_CU_LO +: 4];
        f.mx     = st[ST_MX];
        f.mode   = st[ST_MODE_LO +: 2];
        return f;
    endfunction

    function automatic logic [DATA_W-1:0] thread_field_mask(input int asid_w);
        logic [DATA_W-1:0] m;
        m = '0;
        m[TH_CU_LO +: 4]   = 4'hF;
        m[TH_MX]           = 1'b1;
        m[TH_MODE_LO +: 2] = 2'b11;
        for (int i = 0; i < asid_w; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/stw_write_filter.sv
module stw_write_filter
    import stw_pkg::*;
#(
    parameter logic [DATA_W-1:0] WRITE_MASK = 32'hF118_00F8
) (
    input  logic [DATA_W-1:0] old_val,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rev6_mode,
    input  logic              seg64_en,
    output logic [DATA_W-1:0] new_val
);
    logic [DATA_W-1:0] fdata;
    logic [DATA_W-1:0] fmask;
    logic k_en, s_en, u_en;

    always_comb begin
        fdata = wr_data;
        k_en  = wr_data[ST_KSEG];
        s_en  = wr_data[ST_SSEG] & k_en;
        u_en  = wr_data[ST_USEG] & s_en;
        if (rev6_mode && seg64_en) begin
            fdata[ST_KSEG] = k_en;
            fdata[ST_SSEG] = s_en;
            fdata[ST_USEG] = u_en;
        end
    end

    always_comb begin
        fmask = WRITE_MASK;
        if (rev6_mode) begin
            if (WRITE_MASK[ST_MODE_LO +: 2] == 2'b11 && fdata[ST_MODE_LO +: 2] == 2'b11)
                fmask[ST_MODE_LO +: 2] = 2'b00;
            fmask[ST_SR]  = WRITE_MASK[ST_SR]  & ~fdata[ST_SR];
            fmask[ST_NMI] = WRITE_MASK[ST_NMI] & ~fdata[ST_NMI];
        end
        new_val = (old_val & ~fmask) | (fdata & fmask);
    end
endmodule

// File: rtl/stw_thread_mirror.sv
module stw_thread_mirror
    import stw_pkg::*;
#(
    parameter int ASID_W = 8
) (
    input  logic [DATA_W-1:0] thread_old,
    input  logic [DATA_W-1:0] status_new,
    input  logic [ASID_W-1:0] asid_in,
    output logic [DATA_W-1:0] thread_new
);
    localparam logic [DATA_W-1:0] TMASK = thread_field_mask(ASID_W);

    mirror_fields_t    f;
    logic [DATA_W-1:0] ins;

    always_comb begin
        f   = pick_fields(status_new);
        ins = '0;
        ins[TH_CU_LO +: 4]   = f.usable;
        ins[TH_MX]           = f.mx;
        ins[TH_MODE_LO +: 2] = f.mode;
        ins[ASID_W-1:0]      = asid_in;
        thread_new = (thread_old & ~TMASK) | ins;
    end
endmodule

// File: rtl/stw_seg_watch.sv
module stw_seg_watch
    import stw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              seg64_en,
    input  logic [2:0]        seg_old,
    input  logic [2:0]        seg_new,
    output logic              flush_req
);
    logic dropped;
    assign dropped = wr_en && seg64_en && |(seg_old & ~seg_new);

    always_ff @(posedge clk) begin
        if (rst) flush_req <= 1'b0;
        else     flush_req <= dropped;
    end

    p_flush_cause_r7: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(wr_en) && $past(seg64_en));
endmodule

// File: rtl/status_write_unit.sv
module status_write_unit
    import stw_pkg::*;
#(
    parameter logic [31:0] WRITE_MASK   = 32'hF118_00F8,
    parameter logic [31:0] RESET_STATUS = 32'h0018_00E0,
    parameter logic [31:0] RESET_THREAD = 32'h0055_0000,
    parameter int          ASID_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rev6_mode,
    input  logic              seg64_en,
    input  logic              mt_en,
    input  logic [ASID_W-1:0] asid_in,
    output logic [31:0]       status_q,
    output logic [31:0]       thread_q,
    output logic              flush_req
);
    logic [DATA_W-1:0] status_nx;
    logic [DATA_W-1:0] thread_nx;

    stw_write_filter #(.WRITE_MASK(WRITE_MASK)) u_filter (
        .old_val   (status_q),
        .wr_data   (wr_data),
        .rev6_mode (rev6_mode),
        .seg64_en  (seg64_en),
        .new_val   (status_nx)
    );

    stw_thread_mirror #(.ASID_W(ASID_W)) u_mirror (
        .thread_old (thread_q),
        .status_new (status_nx),
        .asid_in    (asid_in),
        .thread_new (thread_nx)
    );

    stw_seg_watch u_watch (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .seg64_en  (seg64_en),
        .seg_old   (status_q[ST_KSEG:ST_USEG]),
        .seg_new   (status_nx[ST_KSEG:ST_USEG]),
        .flush_req (flush_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= RESET_STATUS;
            thread_q <= RESET_THREAD;
        end else if (wr_en) begin
            status_q <= status_nx;
            if (mt_en) thread_q <= thread_nx;
        end
    end

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(status_q) && $stable(thread_q));

    p_thread_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en && !mt_en |=> $stable(thread_q));

    p_sr_noset_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en && rev6_mode && !status_q[ST_SR] |=> !status_q[ST_SR]);

    p_nmi_noset_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en && rev6_mode && !status_q[ST_NMI] |=> !status_q[ST_NMI]);

    generate
        if (WRITE_MASK[ST_MODE_LO +: 2] == 2'b11) begin : g_mode_chk
            p_mode_reserved_r5: assert property (@(posedge clk) disable iff (rst)
                wr_en && rev6_mode && wr_data[ST_MODE_LO +: 2] == 2'b11
                |=> $stable(status_q[ST_MODE_LO +: 2]));
        end
        if (WRITE_MASK[ST_KSEG:ST_USEG] == 3'b111) begin : g_chain_chk
            p_seg_chain_r3: assert property (@(posedge clk) disable iff (rst)
                wr_en && rev6_mode && seg64_en
                |=> (status_q[ST_SSEG] -> status_q[ST_KSEG]) &&
                    (status_q[ST_USEG] -> status_q[ST_SSEG]));
        end
    endgenerate
endmodule

// File: tb/status_write_unit_tb.sv
module status_write_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rev6_mode, seg64_en, mt_en;
    logic [7:0]  asid_in;
    logic [31:0] status_q, thread_q;
    logic        flush_req;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    status_write_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rev6_mode(rev6_mode), .seg64_en(seg64_en), .mt_en(mt_en),
        .asid_in(asid_in), .status_q(status_q), .thread_q(thread_q),
        .flush_req(flush_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write; returns at the next falling edge, where results are visible
    task automatic wr(input logic [31:0] d, input logic r6, input logic s64, input logic mt);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; rev6_mode = r6; seg64_en = s64; mt_en = mt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_q, 32'h0018_00E0);
        chk("R1 thread", thread_q, 32'h0055_0000);
        chk("R1 flush", {31'b0, flush_req}, 32'h0);
    endtask

    task automatic t_merge;
        wr(32'hFFFF_FFFF, 0, 0, 0);
        chk("R2 set writable", status_q, 32'hF118_00F8);
        wr(32'h0000_0000, 0, 0, 0);
        chk("R2 clear writable", status_q, 32'h0);
        chk("R7 no flush without 64-bit", {31'b0, flush_req}, 32'h0);
        chk("R9 thread frozen", thread_q, 32'h0055_0000);
    endtask

    task automatic t_flags;
        wr(32'h0018_0000, 0, 0, 0);
        chk("R6 set when not rev6", status_q, 32'h0018_0000);
        wr(32'h0000_0000, 1, 0, 0);
        chk("R6 clear in rev6", status_q, 32'h0);
        wr(32'h0018_0000, 1, 0, 0);
        chk("R6 no set in rev6", status_q, 32'h0);
    endtask

    task automatic t_chain;
        wr(32'h0000_00E0, 1, 1, 0);
        chk("R3 all enables", status_q, 32'h0000_00E0);
        chk("R7 no flush on set", {31'b0, flush_req}, 32'h0);
        wr(32'h0000_0060, 1, 1, 0);
        chk("R3 kernel off clears all", status_q, 32'h0);
        chk("R7 flush pulse", {31'b0, flush_req}, 32'h1);
        @(negedge clk);
        chk("R7 pulse ends", {31'b0, flush_req}, 32'h0);
        wr(32'h0000_00E0, 1, 1, 0);
        wr(32'h0000_00A0, 1, 1, 0);
        chk("R3 super off clears user", status_q, 32'h0000_0080);
        chk("R7 flush on chained drop", {31'b0, flush_req}, 32'h1);
    endtask

    task automatic t_nochain;
        wr(32'h0000_0060, 0, 1, 0);
        chk("R4 no chain pre-rev6", status_q, 32'h0000_0060);
        chk("R7 flush kernel drop", {31'b0, flush_req}, 32'h1);
        wr(32'h0000_0060, 0, 1, 0);
        chk("R7 no flush when nothing dropped", {31'b0, flush_req}, 32'h0);
    endtask

    task automatic t_mode;
        wr(32'h0000_0008, 1, 0, 0);
        chk("R5 mode 01 written", status_q, 32'h0000_0008);
        wr(32'h0000_0018, 1, 0, 0);
        chk("R5 mode 11 refused", status_q, 32'h0000_0008);
        wr(32'h0000_0018, 0, 0, 0);
        chk("R5 mode 11 pre-rev6", status_q, 32'h0000_0018);
    endtask

    task automatic t_mirror;
        asid_in = 8'hA5;
        wr(32'hF100_0010, 0, 0, 1);
        chk("R8 status", status_q, 32'hF100_0010);
        chk("R8 thread copy", thread_q, 32'hF855_10A5);
        asid_in = 8'h3C;
        wr(32'h0000_0000, 0, 0, 0);
        chk("R9 status", status_q, 32'h0);
        chk("R9 thread unchanged", thread_q, 32'hF855_10A5);
    endtask

    task automatic t_idle;
        @(negedge clk);
        wr_data = 32'hFFFF_FFFF; mt_en = 1'b1; rev6_mode = 1'b0; seg64_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 status held", status_q, 32'h0);
        chk("R10 thread held", thread_q, 32'hF855_10A5);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        rev6_mode = 1'b0; seg64_en = 1'b0; mt_en = 1'b0; asid_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_merge();
        t_flags();
        t_chain();
        t_nochain();
        t_mode();
        t_mirror();
        t_idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule